// File: doc/BRIEF.md
# Register Bank with Set and Clear Alias Windows

This block holds a small bank of data registers for a peripheral. The bus reaches each register at three addresses. The plain window gives ordinary read and write. The set window ORs the written word into the register. The clear window removes the bits that are 1 in the written word. Because each alias write is one bus cycle with no read phase, software can change single bits or groups of bits without a read-modify-write sequence that another agent could interrupt.

The bus side is a single-cycle register port. The port has an address, a write enable and write data. Read data is combinational from the address. The peripheral side sees every register on a flat output vector. It can raise individual bits through a per-register status-set input. An update to a bit field inside a register is two alias writes: a clear of the field mask, then a set of the new value. The register shows the cleared field for one cycle between the two writes.

Top module: `regalias_bank`

## Requirements
- R1: After reset every register reads as zero and the peripheral output vector is all zeros.
- R2: A write to the plain window replaces the addressed register with the write data on the next clock edge, and a read from the plain window returns the register value.
- R3: A write to the set window makes every bit that is 1 in the write data equal to 1 and leaves every other bit of the register unchanged, in a single clock edge.
- R4: A write to the clear window makes every bit that is 1 in the write data equal to 0 and leaves every other bit of the register unchanged, in a single clock edge.
- R5: Address decoding works as follows. Address bits [11:10] select the window: 00 is plain, 01 is set and 10 is clear. Bits [9:2] give the register index. Bits [1:0] are ignored. A register's set-alias address is therefore 0x400 plus its plain offset, and its clear-alias address is 0x800 plus its plain offset.
- R6: A read from the set window or the clear window returns the current value of the addressed register and changes nothing.
- R7: A 1 on a bit of a register's status-set input sets that bit of the register on the next clock edge.
- R8: If a status-set bit and a clear-window write hit the same bit in the same cycle, the bit ends at 0.
- R9: An address in window 11, or with an index of 8 or more (the number of registers), reads as zero, and a write to it changes no register.
- R10: A plain-window write in the same cycle as a status-set pulse on the same register leaves exactly the written value.
- R11: A field write done as a clear of the mask followed by a set of the value gives (old & ~mask) | value after two edges. The register shows old & ~mask after the first edge.
- R12: A bus write changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Byte address of the access |
| busWe | input | 1 | Write enable for this cycle |
| busWdata | input | 32 | Write data or mask |
| busRdata | output | 32 | Read data for busAddr, combinational |
| hwSet | input | 256 | Status-set bits, register i in bits [32i+31:32i] |
| regOut | output | 256 | Current register values, register i in bits [32i+31:32i] |

## Verification
The assertions assume the following about the inputs:
- Address, write enable and write data carry known values at every clock edge once reset is released.
- The check that a write to an unmapped address leaves the bank unchanged applies only while the status-set input is all zero, because status pulses are allowed to change registers on their own.

How the stimulus meets these assumptions:
- All inputs are driven on the falling edge and held steady through the rising edge.
- Unmapped addresses make up part of the random traffic.
- Sparse status-set pulses are mixed into the random traffic, so some cycles have the status-set input idle and others have it active together with alias writes.

// File: rtl/regalias_pkg.sv
package regalias_pkg;

  typedef enum logic [1:0] {
    WIN_PLAIN = 2'b00,
    WIN_SET   = 2'b01,
    WIN_CLR   = 2'b10,
    WIN_NONE  = 2'b11
  } winKind_e;

  typedef struct packed {
    logic plainWr;
    logic setWr;
    logic clrWr;
    logic rdHit;
  } strobe_t;

endpackage

// File: rtl/regalias_ctrl.sv
module regalias_ctrl
  import regalias_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  localparam int SLOT_W  = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb,
  output logic [SLOT_W-1:0] slot
);

  localparam logic [SLOT_W:0] SLOT_LIMIT = NUM_REGS[SLOT_W:0];

  winKind_e win;
  logic     inRange;
  logic     mapped;

  always_comb begin
    win     = winKind_e'(busAddr[ADDR_W-1 -: 2]);
    slot    = busAddr[ADDR_W-3:2];
    inRange = ({1'b0, slot} < SLOT_LIMIT);
    mapped  = inRange && (win != WIN_NONE);
  end

  always_comb begin
    strb.rdHit   = mapped;
    strb.plainWr = busWe && mapped && (win == WIN_PLAIN);
    strb.setWr   = busWe && mapped && (win == WIN_SET);
    strb.clrWr   = busWe && mapped && (win == WIN_CLR);
  end

endmodule

// File: rtl/regalias_dpath.sv
module regalias_dpath
  import regalias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int SLOT_W   = 8,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [FLAT_W-1:0] hwSet,
  output logic [FLAT_W-1:0] regOut,
  output logic [DATA_W-1:0] busRdata
);

  logic [DATA_W-1:0] regArr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
    logic              selG;
    logic [DATA_W-1:0] setMask;
    logic [DATA_W-1:0] clrMask;
    logic [DATA_W-1:0] nextVal;

    always_comb begin
      selG    = (slot == SLOT_W'(g));
      setMask = hwSet[g*DATA_W +: DATA_W];
      if (selG && strb.setWr) setMask = setMask | busWdata;
      clrMask = (selG && strb.clrWr) ? busWdata : '0;
      if (selG && strb.plainWr) nextVal = busWdata;
      else                      nextVal = (regArr[g] | setMask) & ~clrMask;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regArr[g] <= '0;
      else       regArr[g] <= nextVal;
    end

    assign regOut[g*DATA_W +: DATA_W] = regArr[g];
  end

  always_comb begin
    busRdata = '0;
    if (strb.rdHit) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (slot == SLOT_W'(i)) busRdata = regArr[i];
      end
    end
  end

endmodule

// File: rtl/regalias_bank.sv
module regalias_bank
  import regalias_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  localparam int SLOT_W  = ADDR_W - 4,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [FLAT_W-1:0] hwSet,
  output logic [FLAT_W-1:0] regOut
);

  strobe_t           strb;
  logic [SLOT_W-1:0] slot;

  regalias_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb),
    .slot    (slot)
  );

  regalias_dpath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .slot     (slot),
    .busWdata (busWdata),
    .hwSet    (hwSet),
    .regOut   (regOut),
    .busRdata (busRdata)
  );

endmodule

// File: rtl/regalias_checker.sv
module regalias_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  localparam int FLAT_W  = NUM_REGS * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [FLAT_W-1:0] hwSet,
  input logic [FLAT_W-1:0] regOut
);

  logic [1:0] chkWin;
  logic [31:0] chkIdx;
  logic        chkMapped;

  always_comb begin
    chkWin    = busAddr[ADDR_W-1 -: 2];
    chkIdx    = 32'(busAddr[ADDR_W-3:2]);
    chkMapped = (chkWin != 2'b11) && (chkIdx < NUM_REGS);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    // R2, R5: plain window write lands on register g
    p_plain_write_r2: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && chkWin == 2'b00 && chkIdx == g) |=>
        (regOut[g*DATA_W +: DATA_W] == $past(busWdata)));

    // R3, R5: set window forces mask bits high
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && chkWin == 2'b01 && chkIdx == g) |=>
        ((regOut[g*DATA_W +: DATA_W] & $past(busWdata)) == $past(busWdata)));

    // R4, R8: clear window forces mask bits low even against status pulses
    p_clr_alias_r4: assert property (@(posedge clk) disable iff (!rstN)
      (busWe && chkWin == 2'b10 && chkIdx == g) |=>
        ((regOut[g*DATA_W +: DATA_W] & $past(busWdata)) == '0));

    // R6: any mapped window reads the live register
    p_read_value_r6: assert property (@(posedge clk) disable iff (!rstN)
      (chkMapped && chkIdx == g) |-> (busRdata == regOut[g*DATA_W +: DATA_W]));
  end

  // R9: unmapped reads give zero
  p_unmapped_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chkMapped |-> (busRdata == '0));

  // R9: unmapped writes leave the bank alone while status input is idle
  p_unmapped_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !chkMapped && hwSet == '0) |=> (regOut == $past(regOut)));

endmodule

bind regalias_bank regalias_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .hwSet    (hwSet),
  .regOut   (regOut)
);

// File: tb/regalias_bank_test.sv
module regalias_bank_test;

  localparam int NR = 8;
  localparam int DW = 32;
  localparam int AW = 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWe = 1'b0;
  logic [DW-1:0]   busWdata = '0;
  logic [DW-1:0]   busRdata;
  logic [NR*DW-1:0] hwSet = '0;
  logic [NR*DW-1:0] regOut;

  logic [DW-1:0] model [NR];
  int checks = 0;
  int fails  = 0;

  regalias_bank uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .hwSet(hwSet), .regOut(regOut)
  );

  always #2 clk = ~clk;

  function automatic logic [NR*DW-1:0] hwAt(int r, logic [DW-1:0] v);
    logic [NR*DW-1:0] h;
    h = '0;
    h[r*DW +: DW] = v;
    return h;
  endfunction

  function automatic logic [DW-1:0] refNext(logic [DW-1:0] cur, int kind, bit hit,
                                            bit we, logic [DW-1:0] wd, logic [DW-1:0] hw);
    logic [DW-1:0] r;
    if (we && hit && kind == 0) return wd;
    r = cur | hw;
    if (we && hit && kind == 1) r = r | wd;
    if (we && hit && kind == 2) r = r & ~wd;
    return r;
  endfunction

  function automatic logic [DW-1:0] refRead(logic [AW-1:0] a);
    int kind = int'(a[11:10]);
    int idx  = int'(a[9:2]);
    if (kind == 3 || idx >= NR) return '0;
    return model[idx];
  endfunction

  task automatic compare(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int r = 0; r < NR; r++) compare(tag, regOut[r*DW +: DW], model[r]);
  endtask

  task automatic op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd,
                    logic [NR*DW-1:0] hw, string tag);
    int  kind = int'(a[11:10]);
    int  idx  = int'(a[9:2]);
    bit  hit  = (kind != 3) && (idx < NR);
    logic [DW-1:0] nxt [NR];
    @(negedge clk);
    busWe = we; busAddr = a; busWdata = wd; hwSet = hw;
    for (int r = 0; r < NR; r++)
      nxt[r] = refNext(model[r], kind, hit && (idx == r), we, wd, hw[r*DW +: DW]);
    @(posedge clk);
    #1;
    for (int r = 0; r < NR; r++) model[r] = nxt[r];
    busWe = 1'b0; hwSet = '0;
    checkAll(tag);
  endtask

  task automatic readCheck(logic [AW-1:0] a, string tag);
    @(negedge clk);
    busWe = 1'b0; hwSet = '0; busAddr = a;
    #1;
    compare(tag, busRdata, refRead(a));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) model[r] = '0;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkAll("R1");
    readCheck(12'h000, "R1");

    // R2 plain write and read
    op(1, 12'h008, 32'hA5A5_0F0F, '0, "R2");
    readCheck(12'h008, "R2");
    // R3 set alias at 0x400 + offset
    op(1, 12'h408, 32'h0000_F0F0, '0, "R3");
    compare("R3", model[2], 32'hA5A5_FFFF);
    // R4 clear alias at 0x800 + offset
    op(1, 12'h808, 32'hA5A5_000F, '0, "R4");
    compare("R4", regOut[2*DW +: DW], 32'h0000_FFF0);
    // R6 reads through alias windows
    readCheck(12'h408, "R6");
    readCheck(12'h808, "R6");
    // R5 low address bits ignored
    op(1, 12'h40B, 32'h0000_0001, '0, "R5");
    compare("R5", regOut[2*DW +: DW], 32'h0000_FFF1);
    // R7 status set
    op(0, 12'h000, 32'h0, hwAt(5, 32'h0000_0008), "R7");
    compare("R7", regOut[5*DW +: DW], 32'h0000_0008);
    // R8 clear beats status set
    op(1, 12'h814, 32'h0000_0030, hwAt(5, 32'h0000_00F0), "R8");
    compare("R8", regOut[5*DW +: DW], 32'h0000_00C8);
    // R10 plain write beats status set
    op(1, 12'h014, 32'h0000_0001, hwAt(5, 32'h0000_FF00), "R10");
    compare("R10", regOut[5*DW +: DW], 32'h0000_0001);
    // R9 unmapped window and out-of-range index
    op(1, 12'hC08, 32'hFFFF_FFFF, '0, "R9");
    op(1, 12'h020, 32'hFFFF_FFFF, '0, "R9");
    op(1, 12'h420, 32'hFFFF_FFFF, '0, "R9");
    readCheck(12'hC08, "R9");
    readCheck(12'h020, "R9");
    // R11 two-step field write
    op(1, 12'h00C, 32'h1234_5678, '0, "R11");
    op(1, 12'h80C, 32'h0000_FF00, '0, "R11");
    compare("R11", regOut[3*DW +: DW], 32'h1234_0078);
    op(1, 12'h40C, 32'h0000_AB00, '0, "R11");
    compare("R11", regOut[3*DW +: DW], 32'h1234_AB78);

    // R12 random traffic, whole bank compared after every op
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [NR*DW-1:0] hw;
      a = {2'($urandom % 4), 8'($urandom % 10), 2'($urandom % 4)};
      hw = '0;
      if ($urandom % 4 == 0) hw = hwAt(int'($urandom % NR), $urandom & $urandom);
      op(1'($urandom % 2), a, $urandom, hw, "R12");
      readCheck({2'($urandom % 4), 8'($urandom % 10), 2'b00}, "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule